// File: doc/BRIEF.md
# Basic-Rate ISDN Serial Time-Slot Link, Slave End

This block is the slave side of a full-duplex serial link between a basic-rate ISDN line transceiver and a multiprotocol controller. The transceiver is the link master. It supplies the bit clock on `clk` and a frame sync pulse on `fsync`. The slave never generates either signal. Each frame is twenty bit times long. At the standard 125 µs frame rate this gives 160 kbps in each direction at the same time. The frame carries two 8-bit bearer channels (B1 and B2), two D-channel bits, one auxiliary A bit and one maintenance M bit.

In the receive direction, each enabled bit is captured on the falling edge of `clk`. It is handed to its consumer as the single bit `rx_bit`, together with a one-hot channel strobe. The two D bits of a frame therefore reach the D consumer as one stream of two bits per frame. In the transmit direction, the block takes the bit of the owning channel at the rising edge that opens the bit time and drives it onto `txd`. It asserts `txd_en` only for enabled positions; the pad drives high-impedance whenever `txd_en` is low. A 16-bit mask selects which bearer bit positions take part, so a channel can run below the full 64 kbps. A sync that arrives inside a frame restarts the frame and sets a sticky framing-error flag.

Top module: `bri_link_slave`

## Requirements
- R1: `fsync` is sampled on the rising edge of `clk`. The bit time that starts at the edge where `fsync` is seen high is frame position 0. Each later rising edge advances the position by one, up to position 19. If no sync is seen at the edge after position 19, the link is idle: `txd_en`, `tx_take` and `rx_stb` stay 0 until the next sync.
- R2: Frame positions map to channels as follows. Positions 0–7 are B1 (channel code 0). Position 8 is D (code 2). Position 9 is A (code 3). Positions 10–17 are B2 (code 1). Position 18 is D (code 2). Position 19 is M (code 4). Channel code c corresponds to bit c of `tx_ch`, `tx_take` and `rx_stb`.
- R3: `b_mask[i]` (i = 0..7) enables B1 position i. `b_mask[8+i]` enables B2 position 10+i. D, A and M positions are always enabled. A disabled position is not driven and not routed.
- R4: During an enabled position, `txd_en` is 1 and `txd` equals the bit of the owning channel in `tx_ch`, as sampled at the rising edge that opens that bit time. During every other bit time, `txd_en` is 0 and `txd` is 0.
- R5: For an enabled position, `rxd` is sampled on the falling edge in the middle of the bit time. From that falling edge until the next one, `rx_stb` is one-hot on the owning channel and `rx_bit` holds the sampled value. Otherwise `rx_stb` is 0 and `rx_bit` is 0.
- R6: The two D bits of a frame appear on the D strobe in the order they were received: position 8 first, then position 18.
- R7: A sync seen at a rising edge while the frame is at a position below 19 restarts the frame at position 0 and sets `frame_err`. `frame_err` stays set until reset. A sync seen at position 19 or while idle does not set it.
- R8: While `rst` is high and after it is released, the link is idle, all outputs are 0, and `frame_err` is 0.
- R9: `tx_take` is one-hot on the owning channel during exactly the bit times in which `txd_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the link master |
| rst | input | 1 | Asynchronous reset, active high |
| fsync | input | 1 | Frame sync from the master, sampled on the rising edge |
| rxd | input | 1 | Serial receive data, sampled on the falling edge |
| b_mask | input | 16 | Bearer bit enables: [7:0] for B1, [15:8] for B2 |
| tx_ch | input | 5 | Transmit bit offered by each channel (B1, B2, D, A, M = bits 0..4) |
| txd | output | 1 | Serial transmit data |
| txd_en | output | 1 | Transmit drive enable; the pad is high-impedance when low |
| tx_take | output | 5 | One-hot: the channel whose bit is on `txd` |
| rx_bit | output | 1 | Received bit for the strobed channel |
| rx_stb | output | 5 | One-hot: the channel that owns `rx_bit` |
| frame_err | output | 1 | Sticky flag: a sync arrived inside a frame |

## Verification
The assertions assume the following about the inputs:
- `fsync` changes only away from the rising edge.
- `rxd` is stable around the falling edge.
- `b_mask` is held constant for the whole frame.

The bench behaves as the master. It drives every input 2.5 ns after a falling edge, which is half a phase before the next rising edge, and it changes the mask only between frames. Outputs are sampled 2.5 ns after each edge. This keeps every expected value free of races at the edge, including across the early-sync restart.

// File: rtl/bri_pkg.sv
package bri_pkg;
  localparam int B_BITS     = 8;
  localparam int NCH        = 5;
  localparam int FRAME_BITS = 2 * B_BITS + 4;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int MASK_W     = 2 * B_BITS;

  typedef enum logic [2:0] {
    CH_B1 = 3'd0,
    CH_B2 = 3'd1,
    CH_D  = 3'd2,
    CH_A  = 3'd3,
    CH_M  = 3'd4
  } ch_e;

  // Channel that owns a frame position.
  function automatic ch_e slot_owner(input logic [POS_W-1:0] pos);
    int p;
    p = int'(pos);
    if (p < B_BITS)                 return CH_B1;
    else if (p == B_BITS)           return CH_D;
    else if (p == B_BITS + 1)       return CH_A;
    else if (p < 2 * B_BITS + 2)    return CH_B2;
    else if (p == 2 * B_BITS + 2)   return CH_D;
    else                            return CH_M;
  endfunction

  // Whether a frame position takes part, given the bearer mask.
  function automatic logic slot_enabled(input logic [POS_W-1:0] pos,
                                        input logic [MASK_W-1:0] mask);
    int p;
    p = int'(pos);
    if (p < B_BITS)
      return mask[p];
    else if (p >= B_BITS + 2 && p < 2 * B_BITS + 2)
      return mask[p - 2];
    else
      return 1'b1;
  endfunction

  function automatic logic [NCH-1:0] ch_onehot(input ch_e c);
    return NCH'(1) << c;
  endfunction
endpackage

// File: rtl/bri_frame_counter.sv
module bri_frame_counter
  import bri_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [POS_W-1:0] pos,
  output logic             live,
  output logic [POS_W-1:0] nxt_pos,
  output logic             nxt_live,
  output logic             early_sync,
  output logic             frame_err
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  always_comb begin
    early_sync = fsync && live && (pos != LAST);
    if (fsync) begin
      nxt_live = 1'b1;
      nxt_pos  = '0;
    end else if (live && pos != LAST) begin
      nxt_live = 1'b1;
      nxt_pos  = pos + 1'b1;
    end else begin
      nxt_live = 1'b0;
      nxt_pos  = '0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos       <= '0;
      live      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      pos  <= nxt_pos;
      live <= nxt_live;
      if (early_sync) frame_err <= 1'b1;
    end
  end

  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
    live |-> (pos <= LAST));
  p_sync_restart_r1: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (live && pos == '0));
  p_advance_r1: assert property (@(posedge clk) disable iff (rst)
    (live && !fsync && pos != LAST) |=> (live && pos == $past(pos) + 1'b1));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    early_sync |=> frame_err);
endmodule

// File: rtl/bri_tx_mux.sv
module bri_tx_mux
  import bri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic              nxt_live,
  input  logic [MASK_W-1:0] b_mask,
  input  logic [NCH-1:0]    tx_ch,
  output logic              txd,
  output logic              txd_en,
  output logic [NCH-1:0]    tx_take
);
  logic go;
  ch_e  own;

  always_comb begin
    own = slot_owner(nxt_pos);
    go  = nxt_live && slot_enabled(nxt_pos, b_mask);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      txd     <= 1'b0;
      txd_en  <= 1'b0;
      tx_take <= '0;
    end else begin
      txd_en  <= go;
      txd     <= go ? tx_ch[own] : 1'b0;
      tx_take <= go ? ch_onehot(own) : '0;
    end
  end

  p_take_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_take));
  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !txd_en |-> (txd == 1'b0 && tx_take == '0));
endmodule

// File: rtl/bri_rx_router.sv
module bri_rx_router
  import bri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [POS_W-1:0]  pos,
  input  logic              live,
  input  logic [MASK_W-1:0] b_mask,
  input  logic              rxd,
  output logic              rx_bit,
  output logic [NCH-1:0]    rx_stb
);
  logic hit;
  ch_e  own;

  always_comb begin
    own = slot_owner(pos);
    hit = live && slot_enabled(pos, b_mask);
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      rx_bit <= 1'b0;
      rx_stb <= '0;
    end else begin
      rx_bit <= hit ? rxd : 1'b0;
      rx_stb <= hit ? ch_onehot(own) : '0;
    end
  end

  p_rx_onehot_r5: assert property (@(negedge clk) disable iff (rst)
    $onehot0(rx_stb));
  p_rx_quiet_r5: assert property (@(negedge clk) disable iff (rst)
    (rx_stb == '0) |-> (rx_bit == 1'b0));
endmodule

// File: rtl/bri_link_slave.sv
module bri_link_slave
  import bri_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              rxd,
  input  logic [MASK_W-1:0] b_mask,
  input  logic [NCH-1:0]    tx_ch,
  output logic              txd,
  output logic              txd_en,
  output logic [NCH-1:0]    tx_take,
  output logic              rx_bit,
  output logic [NCH-1:0]    rx_stb,
  output logic              frame_err
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] nxt_pos;
  logic             live;
  logic             nxt_live;
  logic             early_sync;

  bri_frame_counter u_cnt (
    .clk(clk), .rst(rst), .fsync(fsync),
    .pos(pos), .live(live), .nxt_pos(nxt_pos), .nxt_live(nxt_live),
    .early_sync(early_sync), .frame_err(frame_err)
  );

  bri_tx_mux u_tx (
    .clk(clk), .rst(rst), .nxt_pos(nxt_pos), .nxt_live(nxt_live),
    .b_mask(b_mask), .tx_ch(tx_ch),
    .txd(txd), .txd_en(txd_en), .tx_take(tx_take)
  );

  bri_rx_router u_rx (
    .clk(clk), .rst(rst), .pos(pos), .live(live), .b_mask(b_mask),
    .rxd(rxd), .rx_bit(rx_bit), .rx_stb(rx_stb)
  );

  p_tx_needs_live_r4: assert property (@(posedge clk) disable iff (rst)
    txd_en |-> live);
  p_take_tracks_en_r9: assert property (@(posedge clk) disable iff (rst)
    txd_en |-> $onehot(tx_take));
endmodule

// File: tb/sim_bri_link_slave.sv
module sim_bri_link_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0;
  logic        rxd = 1'b0;
  logic [15:0] b_mask = 16'h0;
  logic [4:0]  tx_ch = 5'h0;
  logic        txd, txd_en, rx_bit, frame_err;
  logic [4:0]  tx_take, rx_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bri_link_slave u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .rxd(rxd), .b_mask(b_mask),
    .tx_ch(tx_ch), .txd(txd), .txd_en(txd_en), .tx_take(tx_take),
    .rx_bit(rx_bit), .rx_stb(rx_stb), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Channel code of frame position k (restated from the requirements).
  function automatic int owner_of(input int k);
    if (k < 8) return 0;
    if (k == 8) return 2;
    if (k == 9) return 3;
    if (k < 18) return 1;
    if (k == 18) return 2;
    return 4;
  endfunction

  function automatic bit used(input int k, input logic [15:0] m);
    if (k < 8) return m[k];
    if (k >= 10 && k < 18) return m[k - 2];
    return 1'b1;
  endfunction

  // Drives len bit times of a frame, starting with a sync, and checks each one.
  // Entry and exit are 2.5 ns after a falling edge.
  task automatic send_frame(input logic [15:0] m, input int len, input string tag);
    logic [1:0] d_seen = 2'b00;
    logic [1:0] d_sent = 2'b00;
    int dn = 0;
    b_mask = m;
    for (int k = 0; k < len; k++) begin
      logic [4:0] tv;
      logic       rv;
      int         ow;
      bit         en;
      tv = 5'($urandom);
      rv = 1'($urandom);
      ow = owner_of(k);
      en = used(k, m);
      fsync = (k == 0);
      tx_ch = tv;
      rxd   = rv;
      @(posedge clk); #2.5;
      chk(txd_en == en, {tag, " R4 txd_en"}, txd_en, en);
      chk(txd == (en ? tv[ow] : 1'b0), {tag, " R4 R2 txd"}, txd, en ? tv[ow] : 0);
      chk(tx_take == (en ? 5'(1 << ow) : 5'h0), {tag, " R9 R3 tx_take"}, tx_take,
          en ? (1 << ow) : 0);
      @(negedge clk); #2.5;
      chk(rx_stb == (en ? 5'(1 << ow) : 5'h0), {tag, " R5 R2 rx_stb"}, rx_stb,
          en ? (1 << ow) : 0);
      chk(rx_bit == (en ? rv : 1'b0), {tag, " R5 rx_bit"}, rx_bit, en ? rv : 0);
      if (k == 8 || k == 18) d_sent = {d_sent[0], rv};
      if (rx_stb == 5'b00100) begin
        d_seen = {d_seen[0], rx_bit};
        dn++;
      end
    end
    fsync = 1'b0;
    if (len == 20) begin
      chk(dn == 2, {tag, " R6 D count"}, dn, 2);
      chk(d_seen == d_sent, {tag, " R6 D order"}, d_seen, d_sent);
    end
  endtask

  task automatic idle_bits(input int n);
    fsync = 1'b0;
    for (int k = 0; k < n; k++) begin
      tx_ch = 5'($urandom);
      rxd   = 1'($urandom);
      @(posedge clk); #2.5;
      chk(txd_en == 1'b0 && tx_take == 5'h0, "R1 idle tx", {txd_en, tx_take}, 0);
      @(negedge clk); #2.5;
      chk(rx_stb == 5'h0, "R1 idle rx", rx_stb, 0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #2.5;
    chk({txd, txd_en, tx_take, rx_bit, rx_stb, frame_err} == '0, "R8 reset outputs",
        {txd, txd_en, tx_take, rx_bit, rx_stb, frame_err}, 0);
    @(negedge clk); #2.5;
    rst = 1'b0;
    idle_bits(2);
    chk(frame_err == 1'b0, "R8 err after reset", frame_err, 0);
  endtask

  task automatic t_full_frames;
    send_frame(16'hFFFF, 20, "full");
    idle_bits(3);
    send_frame(16'h0000, 20, "nomask");
    send_frame(16'b0001_1100_1100_0000, 20, "b1x2_b2x3");
    send_frame(16'($urandom), 20, "rand1");
    send_frame(16'($urandom), 20, "rand2");
    chk(frame_err == 1'b0, "R7 no err on aligned sync", frame_err, 0);
  endtask

  task automatic t_early_sync;
    send_frame(16'hA55A, 7, "short");
    chk(frame_err == 1'b0, "R7 err before restart", frame_err, 0);
    send_frame(16'h5AA5, 20, "restart");
    chk(frame_err == 1'b1, "R7 err set", frame_err, 1);
    idle_bits(2);
    send_frame(16'($urandom), 20, "after_err");
    chk(frame_err == 1'b1, "R7 err sticky", frame_err, 1);
  endtask

  initial begin
    t_reset();
    t_full_frames();
    t_early_sync();
    idle_bits(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule